// File: doc/BRIEF.md
# Split-Rate Programmable Interval Timer

This block produces a periodic one-cycle tick whose spacing is set by a 48-bit preset, with one clock of resolution. The count is held in two cascaded down counters: a narrow fast stage that steps on every clock and a wide slow stage that steps only when the fast stage wraps through zero. As a result, most of the counter bits change at 1/256 of the clock rate.

A host writes a new preset into a shadow register at any time. The running period is never disturbed by that write. The slow stage takes its next value early, at the moment it would otherwise reach zero. After that, the fast stage runs one last full wrap to the period boundary. This keeps every action of the wide counter at the slow rate. Consecutive periods follow each other with no idle cycle. An enable input pauses the timer, and restarting it begins a fresh period from the preset.

Top module: `split_interval_timer`

## Requirements
- R1: With preset P (an unsigned 48-bit value), consecutive ticks are exactly P+1 clock cycles apart. A preset of 0 gives a tick on every cycle.
- R2: Periods follow each other back to back. While the timer is enabled and the preset is unchanged, every gap between ticks is the same.
- R3: The upper 40 bits of the preset (bits 47:8) set the slow stage and the low 8 bits (bits 7:0) set the fast stage. The slow stage steps once per full 256-cycle wrap of the fast stage, so presets that have a nonzero upper field still give P+1 cycles.
- R4: The slow stage is reloaded at the step where it would reach zero, while the fast stage then reads all ones. The period ends after that final 256-cycle wrap. Presets whose upper field is 1 (values 256 to 511) still give P+1 cycles.
- R5: For a preset of 1 or more, the tick is high for exactly one cycle per period.
- R6: A preset write lands in a shadow register and leaves the running period unchanged. In that case the write takes effect for the very next period, provided it arrives before the final fast-stage wrap of a period with a nonzero upper field.
- R7: If the write arrives during that final 256-cycle wrap, the current period and the period after it keep the old preset, and the new preset applies from the following boundary.
- R8: While enable is low, the tick stays low and the counters follow the shadow preset. After enable rises, the first tick comes on the (P+1)th enabled cycle and the tick is visible one cycle later.
- R9: Reset drives the tick low and loads the shadow register with the parameter RST_PRESET (default 999). If the timer is enabled straight after reset with no write, the first tick therefore comes on enabled cycle 1000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock; one period step per cycle |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low holds the timer loaded from the shadow preset |
| wr_en | input | 1 | Single-cycle strobe that captures wr_preset into the shadow register |
| wr_preset | input | 48 | New period preset P (period is P+1 cycles) |
| tick | output | 1 | Registered one-cycle pulse at each period boundary |

## Verification
The assertions take en, wr_en and wr_preset to be synchronous to clk and free of unknown values once reset is released. They also assume reset is held for several cycles, so every stage starts from its reset load. The stimulus changes inputs only on falling clock edges and drives wr_en as a one-cycle pulse. Mid-run writes are placed at known cycle offsets from a tick, which puts them clearly before or clearly inside the final fast-stage wrap and never on the commit edge.

// File: rtl/sit_pkg.sv
package sit_pkg;
  localparam int unsigned SIT_LO_W = 8;
  localparam int unsigned SIT_HI_W = 40;

  // What both stages do on the coming clock edge.
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,  // disabled: follow the shadow preset
    ACT_STEP = 2'd1,  // fast stage decrements, slow stage idles
    ACT_WRAP = 2'd2,  // fast stage wraps through zero, slow stage steps
    ACT_END  = 2'd3   // period boundary: reload for the next period
  } stage_act_e;
endpackage

// File: rtl/sit_shadow.sv
module sit_shadow #(
  parameter int unsigned           W         = 48,
  parameter logic [W-1:0]          RST_VALUE = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] pend
);
  always_ff @(posedge clk) begin
    if (rst)        pend <= RST_VALUE;
    else if (wr_en) pend <= wr_data;
  end

  // The shadow only changes on a host strobe.
  p_shadow_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(pend));
endmodule

// File: rtl/sit_fast.sv
module sit_fast
  import sit_pkg::*;
#(
  parameter int unsigned      LO_W   = 8,
  parameter logic [LO_W-1:0]  RST_LO = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  stage_act_e      act,
  input  logic            commit,     // slow stage took its early reload
  input  logic            use_saved,  // low field was captured at that reload
  input  logic [LO_W-1:0] pend_lo,
  output logic [LO_W-1:0] lo,
  output logic            lo_zero
);
  localparam logic [LO_W-1:0] LO_ONE = {{(LO_W-1){1'b0}}, 1'b1};

  logic [LO_W-1:0] saved_lo;

  assign lo_zero = (lo == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      lo       <= RST_LO;
      saved_lo <= RST_LO;
    end else begin
      unique case (act)
        ACT_HOLD: lo <= pend_lo;
        ACT_END:  lo <= use_saved ? saved_lo : pend_lo;
        default:  lo <= lo - LO_ONE;  // wraps 0 -> all ones on ACT_WRAP
      endcase
      if (commit) saved_lo <= pend_lo;
    end
  end

  // A plain step never starts from zero; zero always means wrap or end.
  p_step_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_STEP) |=> (lo == $past(lo) - LO_ONE));
endmodule

// File: rtl/sit_slow.sv
module sit_slow
  import sit_pkg::*;
#(
  parameter int unsigned      HI_W   = 40,
  parameter logic [HI_W-1:0]  RST_HI = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  stage_act_e      act,
  input  logic [HI_W-1:0] pend_hi,
  output logic [HI_W-1:0] hi,
  output logic            fin,     // final fast-stage wrap of this period
  output logic            armed,   // next period's preset already taken
  output logic            commit
);
  localparam logic [HI_W-1:0] HI_ONE = {{(HI_W-1){1'b0}}, 1'b1};

  logic hi_one;

  assign hi_one = (hi == HI_ONE);
  assign commit = (act == ACT_WRAP) && hi_one;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi    <= RST_HI;
      fin   <= (RST_HI == '0);
      armed <= 1'b0;
    end else begin
      unique case (act)
        ACT_HOLD: begin
          hi    <= pend_hi;
          fin   <= (pend_hi == '0);
          armed <= 1'b0;
        end
        ACT_END: begin
          if (armed) begin
            fin   <= (hi == '0);
            armed <= 1'b0;
          end else begin
            hi  <= pend_hi;
            fin <= (pend_hi == '0);
          end
        end
        ACT_WRAP: begin
          if (hi_one) begin
            hi    <= pend_hi;  // early reload, one full wrap before the end
            fin   <= 1'b1;
            armed <= 1'b1;
          end else begin
            hi <= hi - HI_ONE;
          end
        end
        default: ;
      endcase
    end
  end

  // The wide stage moves only at wrap, boundary or disabled load.
  p_slow_rate_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(hi) |-> $past(act != ACT_STEP));
  // A wrap never happens during the final wrap.
  p_wrap_not_final_r4: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_WRAP) |-> !fin);
endmodule

// File: rtl/split_interval_timer.sv
module split_interval_timer
  import sit_pkg::*;
#(
  parameter int unsigned                    LO_W       = SIT_LO_W,
  parameter int unsigned                    HI_W       = SIT_HI_W,
  parameter logic [LO_W+HI_W-1:0]           RST_PRESET = 999
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic                 wr_en,
  input  logic [LO_W+HI_W-1:0] wr_preset,
  output logic                 tick
);
  localparam int unsigned     W      = LO_W + HI_W;
  localparam logic [LO_W-1:0] RST_LO = RST_PRESET[LO_W-1:0];
  localparam logic [HI_W-1:0] RST_HI = RST_PRESET[W-1:LO_W];

  logic [W-1:0]    pend;
  logic [LO_W-1:0] lo;
  logic [HI_W-1:0] hi;
  logic            lo_zero;
  logic            fin;
  logic            armed;
  logic            commit;
  stage_act_e      act;
  logic            tick_q;

  sit_shadow #(.W(W), .RST_VALUE(RST_PRESET)) u_shadow (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_preset), .pend(pend)
  );

  always_comb begin
    if (!en)                 act = ACT_HOLD;
    else if (lo_zero && fin) act = ACT_END;
    else if (lo_zero)        act = ACT_WRAP;
    else                     act = ACT_STEP;
  end

  sit_fast #(.LO_W(LO_W), .RST_LO(RST_LO)) u_fast (
    .clk(clk), .rst(rst), .act(act), .commit(commit), .use_saved(armed),
    .pend_lo(pend[LO_W-1:0]), .lo(lo), .lo_zero(lo_zero)
  );

  sit_slow #(.HI_W(HI_W), .RST_HI(RST_HI)) u_slow (
    .clk(clk), .rst(rst), .act(act), .pend_hi(pend[W-1:LO_W]),
    .hi(hi), .fin(fin), .armed(armed), .commit(commit)
  );

  always_ff @(posedge clk) begin
    if (rst) tick_q <= 1'b0;
    else     tick_q <= (act == ACT_END);
  end

  assign tick = tick_q;

  // Early reload leaves the fast stage at all ones with the final wrap flagged.
  p_early_reload_r4: assert property (@(posedge clk) disable iff (rst)
    commit |=> (lo == '1) && fin && armed);
  // Disabled timer never ticks.
  p_quiet_off_r8: assert property (@(posedge clk) disable iff (rst)
    !en |=> !tick);
  // A tick follows only an enabled cycle with both stages spent.
  p_tick_end_r1: assert property (@(posedge clk) disable iff (rst)
    tick |-> $past(en && fin && (lo == '0)));
  // Next period starts at once: after a boundary the timer is still running.
  p_no_gap_r2: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_END) |=> (!armed));
endmodule

// File: tb/split_interval_timer_bench.sv
`timescale 1ns/1ps
module split_interval_timer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic        wr_en = 1'b0;
  logic [47:0] wr_preset = '0;
  logic        tick;

  int checks = 0;
  int errors = 0;

  localparam int NV = 10;
  localparam logic [47:0] PRE [NV] = '{48'd0, 48'd1, 48'd7, 48'd255, 48'd256,
                                       48'd257, 48'd511, 48'd768, 48'd1000, 48'd677};
  localparam int GAP [NV] = '{1, 2, 8, 256, 257, 258, 512, 769, 1001, 678};
  localparam int LIMIT = 5000;

  always #2.5 clk = ~clk;

  split_interval_timer u_split_interval_timer (
    .clk(clk), .rst(rst), .en(en), .wr_en(wr_en), .wr_preset(wr_preset), .tick(tick)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_tick(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tick && n < LIMIT);
  endtask

  task automatic write_preset(input logic [47:0] v);
    wr_preset = v;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic restart(input logic [47:0] v);
    en = 1'b0;
    @(negedge clk);
    write_preset(v);
    repeat (2) @(negedge clk);
    en = 1'b1;
  endtask

  initial begin
    repeat (LIMIT * 30) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    int quiet;
    // R9: reset state and reset preset
    repeat (4) @(negedge clk);
    chk("R9 tick low in reset", tick, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 tick low after reset", tick, 0);
    en = 1'b1;
    wait_tick(n);
    chk("R9 first tick from reset preset", n, 1000);

    // Vector table: first tick after enable, then two steady gaps
    for (int i = 0; i < NV; i++) begin
      restart(PRE[i]);
      wait_tick(n);
      chk("R8 first tick after enable", n, GAP[i]);
      if (GAP[i] > 1) begin
        @(negedge clk);
        chk("R5 tick single cycle", tick, 0);
        wait_tick(n);
        n = n + 1;
      end else begin
        wait_tick(n);
      end
      if (PRE[i] >= 48'd256 && PRE[i] < 48'd512)
        chk("R4 gap with upper field 1", n, GAP[i]);
      else if (PRE[i] >= 48'd256)
        chk("R3 gap with nonzero upper field", n, GAP[i]);
      else
        chk("R1 gap equals preset plus one", n, GAP[i]);
      wait_tick(n);
      chk("R2 back-to-back gap repeats", n, GAP[i]);
    end

    // R6: write well before the final wrap applies at the next boundary
    restart(48'd1000);
    wait_tick(n);
    repeat (99) @(negedge clk);
    write_preset(48'd300);
    wait_tick(n);
    chk("R6 running period unchanged", n + 100, 1001);
    wait_tick(n);
    chk("R6 new preset next period", n, 301);

    // R7: write inside the final wrap applies one boundary later
    restart(48'd1000);
    wait_tick(n);
    repeat (949) @(negedge clk);
    write_preset(48'd300);
    wait_tick(n);
    chk("R7 running period unchanged", n + 950, 1001);
    wait_tick(n);
    chk("R7 next period keeps old preset", n, 1001);
    wait_tick(n);
    chk("R7 new preset one boundary later", n, 301);

    // R8: disabled timer stays quiet
    en = 1'b0;
    quiet = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (k > 0 && tick) quiet++;
    end
    chk("R8 no tick while disabled", quiet, 0);
    en = 1'b1;
    wait_tick(n);
    chk("R8 restart from preset", n, 301);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule